// File: doc/BRIEF.md
# Framed Audio Serial Transmitter

This block is the sending side of a two-channel audio link in which it drives the clocks. It divides the system clock down to a bit clock and drives a channel clock that also serves as the frame sync. It shifts out one left sample and one right sample per frame on a single serial data line. A 2-bit format selector picks one of four frame layouts. In each layout a sample of one width is placed inside a channel slot that may be wider. The data always changes on the rising edge of the bit clock, so a receiver samples on the falling edge.

Sample pairs come in on a parallel interface with a valid/ready handshake. The ready strobe rises for one system clock cycle at each frame boundary. At that moment the block takes the pair, the format and the sync-alignment choice, and holds all of them for the whole frame. When no pair is offered at a boundary, the frame carries silence and a one-cycle underrun flag is raised.

Top module: `audio_frame_tx`

## Requirements
- R1: `bitClk` is low in reset and afterwards runs freely, with a period of 2*CLK_HALF system clock cycles and a high time of CLK_HALF cycles.
- R2: `serData` and `chanClk` change only in the cycle in which `bitClk` rises (low-to-high). No format setting moves the transmit edge.
- R3: The format code `modeSel` works as follows. 00 gives 16-bit samples in 16-bit slots (32-bit frame). 01 gives 16-bit samples in 32-bit slots (64-bit frame). 10 gives 32-bit samples in 32-bit slots (64-bit frame). 11 gives 24-bit samples in 32-bit slots (64-bit frame).
- R4: Each sample is taken from the low bits of its 32-bit input word. It is sent MSB first, starting at the first bit of its slot, and the rest of the slot is sent as zeros. The left word goes first, with `chanClk` low, and the right word follows with `chanClk` high.
- R5: With `syncAlign`=1, `chanClk` falls on the first bit of the frame and rises on the first bit of the right slot. With `syncAlign`=0, each of these transitions comes one bit earlier: on the last bit of the previous frame, and on the last bit of the left slot.
- R6: `sampleReady` is high for exactly one system clock cycle per frame, in the cycle just before the frame's first bit begins. The pair is taken when `sampleValid` is high in that cycle. `modeSel` and `syncAlign` are sampled in that same cycle and held for the whole frame.
- R7: If `sampleValid` is low while `sampleReady` is high, both slots of that frame are sent as zeros. `underrun` is then high for exactly the next system clock cycle.
- R8: While `rstN` is low: `bitClk`=0, `chanClk`=1, `serData`=0, `sampleReady`=0 and `underrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Frame format code, sampled at the frame boundary |
| syncAlign | input | 1 | 1: sync edge on the first bit; 0: sync edge one bit earlier |
| sampleValid | input | 1 | A sample pair is offered |
| sampleReady | output | 1 | Frame boundary strobe; the pair is taken when valid is high |
| leftWord | input | 32 | Left sample, right-justified on the bus |
| rightWord | input | 32 | Right sample, right-justified on the bus |
| bitClk | output | 1 | Serial bit clock |
| chanClk | output | 1 | Channel clock / frame sync, low for the left slot |
| serData | output | 1 | Serial data, MSB first |
| underrun | output | 1 | One-cycle pulse when a frame starts with no pair offered |

## Verification
The bench builds the block with CLK_HALF=3. This gives a six-cycle bit period whose divider wraps at a value that is not a power of two, and a high time of three cycles, so a wrong wrap point or an asymmetric duty cycle changes the measured periods. Its frames cover all four formats, both sync alignments, and changes of format and alignment between consecutive frames, including a switch from a 64-bit frame down to a 32-bit one. Between boundaries the bench drives scrambled words and settings, and it leaves garbage in the unused upper bus bits. It also runs silent frames, so the checks reach the latching of inputs, the zero fill and the underrun pulse.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam int SAMPLE_W = 32;   // parallel sample bus width
  localparam int POS_W    = 6;    // bit position within a frame of up to 64 bits

  typedef logic [POS_W:0] widthT;

  // Strobes from control to datapath
  typedef struct packed {
    logic bitEdge;     // last cycle of a bit period: outputs advance at this edge
    logic frameStart;  // bitEdge that also starts a new frame
  } txStrobeT;

  function automatic widthT slotBits(input logic [1:0] mode);
    return (mode == 2'b00) ? widthT'(16) : widthT'(32);
  endfunction

  function automatic widthT dataBits(input logic [1:0] mode);
    case (mode)
      2'b10:   return widthT'(32);
      2'b11:   return widthT'(24);
      default: return widthT'(16);
    endcase
  endfunction
endpackage

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
#(
  parameter int CLK_HALF = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] frameLast,
  output txStrobeT         strobes,
  output logic [POS_W-1:0] nextPos,
  output logic             bitClk
);
  localparam int PERIOD = 2 * CLK_HALF;
  localparam int DIV_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [DIV_W-1:0] divCnt;
  logic [POS_W-1:0] bitPos;
  logic             atLast;
  logic             bitMid;

  assign atLast             = bitPos >= frameLast;
  assign bitMid             = divCnt == DIV_W'(CLK_HALF - 1);
  assign strobes.bitEdge    = divCnt == DIV_W'(PERIOD - 1);
  assign strobes.frameStart = strobes.bitEdge && atLast;
  assign nextPos            = atLast ? '0 : bitPos + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      bitPos <= '1;   // parked past any frame end: the first edge opens a frame
      bitClk <= 1'b0;
    end else begin
      divCnt <= strobes.bitEdge ? '0 : divCnt + 1'b1;
      if (strobes.bitEdge) begin
        bitPos <= nextPos;
        bitClk <= 1'b1;
      end else if (bitMid) begin
        bitClk <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_tx_datapath.sv
module audio_tx_datapath
  import audio_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  txStrobeT            strobes,
  input  logic [POS_W-1:0]    nextPos,
  input  logic [1:0]          modeSel,
  input  logic                syncAlign,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] leftWord,
  input  logic [SAMPLE_W-1:0] rightWord,
  output logic [POS_W-1:0]    frameLast,
  output logic                serData,
  output logic                chanClk,
  output logic                underrun
);
  localparam int SEL_W = $clog2(SAMPLE_W);

  logic [1:0]          modeReg, nxtMode;
  logic                alignReg, nxtAlign;
  logic [SAMPLE_W-1:0] leftReg, rightReg, nxtLeft, nxtRight, word;
  widthT               slotW, dataW, posW, idx;
  logic [SEL_W-1:0]    sel;
  logic                inRight, bitVal, chanVal;

  assign frameLast = POS_W'((slotBits(modeReg) << 1) - widthT'(1));

  always_comb begin
    if (strobes.frameStart) begin
      nxtMode  = modeSel;
      nxtAlign = syncAlign;
      nxtLeft  = sampleValid ? leftWord  : '0;
      nxtRight = sampleValid ? rightWord : '0;
    end else begin
      nxtMode  = modeReg;
      nxtAlign = alignReg;
      nxtLeft  = leftReg;
      nxtRight = rightReg;
    end
    slotW   = slotBits(nxtMode);
    dataW   = dataBits(nxtMode);
    posW    = {1'b0, nextPos};
    inRight = posW >= slotW;
    idx     = inRight ? posW - slotW : posW;
    word    = inRight ? nxtRight : nxtLeft;
    sel     = SEL_W'(dataW - widthT'(1) - idx);
    bitVal  = (idx < dataW) ? word[sel] : 1'b0;
    // early sync: the slot's level is taken one bit ahead
    chanVal = nxtAlign ? inRight
                       : ((posW + widthT'(1) >= slotW) && (posW + widthT'(1) < (slotW << 1)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= 2'b00;
      alignReg <= 1'b0;
      leftReg  <= '0;
      rightReg <= '0;
      serData  <= 1'b0;
      chanClk  <= 1'b1;
      underrun <= 1'b0;
    end else begin
      underrun <= strobes.frameStart && !sampleValid;
      if (strobes.frameStart) begin
        modeReg  <= nxtMode;
        alignReg <= nxtAlign;
        leftReg  <= nxtLeft;
        rightReg <= nxtRight;
      end
      if (strobes.bitEdge) begin
        serData <= bitVal;
        chanClk <= chanVal;
      end
    end
  end
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import audio_tx_pkg::*;
#(
  parameter int CLK_HALF = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          modeSel,
  input  logic                syncAlign,
  input  logic                sampleValid,
  output logic                sampleReady,
  input  logic [SAMPLE_W-1:0] leftWord,
  input  logic [SAMPLE_W-1:0] rightWord,
  output logic                bitClk,
  output logic                chanClk,
  output logic                serData,
  output logic                underrun
);
  txStrobeT         strobes;
  logic [POS_W-1:0] nextPos;
  logic [POS_W-1:0] frameLast;

  assign sampleReady = strobes.frameStart;

  audio_tx_ctrl #(.CLK_HALF(CLK_HALF)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameLast(frameLast),
    .strobes  (strobes),
    .nextPos  (nextPos),
    .bitClk   (bitClk)
  );

  audio_tx_datapath u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .nextPos    (nextPos),
    .modeSel    (modeSel),
    .syncAlign  (syncAlign),
    .sampleValid(sampleValid),
    .leftWord   (leftWord),
    .rightWord  (rightWord),
    .frameLast  (frameLast),
    .serData    (serData),
    .chanClk    (chanClk),
    .underrun   (underrun)
  );
endmodule

// File: rtl/audio_frame_tx_chk.sv
module audio_frame_tx_chk (
  input logic clk,
  input logic rstN,
  input logic sampleValid,
  input logic sampleReady,
  input logic bitClk,
  input logic chanClk,
  input logic serData,
  input logic underrun
);
  assert_data_on_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(bitClk) |-> $stable(serData));

  assert_sync_on_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(bitClk) |-> $stable(chanClk));

  assert_ready_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |=> !sampleReady);

  assert_first_bit_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |=> $rose(bitClk));

  assert_underrun_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> $past(sampleReady && !sampleValid));

  assert_underrun_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun);
endmodule

bind audio_frame_tx audio_frame_tx_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .sampleReady(sampleReady),
  .bitClk     (bitClk),
  .chanClk    (chanClk),
  .serData    (serData),
  .underrun   (underrun)
);

// File: tb/audio_frame_tx_tb.sv
module audio_frame_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  typedef struct packed { logic d; logic c; } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic        syncAlign = 1'b0;
  logic        sampleValid = 1'b0;
  logic [31:0] leftWord = '0;
  logic [31:0] rightWord = '0;
  logic        sampleReady, bitClk, chanClk, serData, underrun;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  expT expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_frame_tx #(.CLK_HALF(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .syncAlign(syncAlign),
    .sampleValid(sampleValid), .sampleReady(sampleReady),
    .leftWord(leftWord), .rightWord(rightWord),
    .bitClk(bitClk), .chanClk(chanClk), .serData(serData), .underrun(underrun)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected bit stream of one frame, built from R3, R4 and R5
  task automatic pushFrame(logic [1:0] mode, bit align, logic [31:0] l, logic [31:0] r);
    int w = (mode == 2'b00) ? 16 : 32;
    int f = 2 * w;
    int d = (mode == 2'b10) ? 32 : (mode == 2'b11) ? 24 : 16;
    for (int p = 0; p < f; p++) begin
      bit          inR = (p >= w);
      int          k   = inR ? p - w : p;
      logic [31:0] wd  = inR ? r : l;
      expT         e;
      e.d = (k < d) ? wd[d - 1 - k] : 1'b0;
      e.c = align ? inR : ((p + 1 >= w) && (p + 1 < f));
      expQ.push_back(e);
    end
  endtask

  // Driver: offer one frame, wait for the boundary, then scramble the inputs
  task automatic runFrame(bit valid, logic [1:0] mode, bit align, logic [31:0] l, logic [31:0] r);
    modeSel = mode; syncAlign = align; sampleValid = valid; leftWord = l; rightWord = r;
    do @(negedge clk); while (!sampleReady);
    if (valid) pushFrame(mode, align, l, r);
    else       pushFrame(mode, align, 32'h0, 32'h0);
    @(negedge clk);
    check("R6 ready lasts one cycle", sampleReady, 0);
    check("R7 underrun after boundary", underrun, !valid);
    modeSel = ~mode; syncAlign = ~align; leftWord = ~l; rightWord = ~r; sampleValid = 1'b1;
    @(negedge clk);
    check("R7 underrun one cycle only", underrun, 0);
    check("R6 no second ready in frame", sampleReady, 0);
  endtask

  // Monitor: scoreboard compare at every bit clock rise
  logic prevBit = 1'b0;
  logic lastData = 1'b0;
  int   cyc = 0;
  int   lastRise = -1;
  expT  got;
  always @(negedge clk) begin
    cyc++;
    if (rstN && !finished) begin
      if (bitClk && !prevBit) begin
        if (lastRise >= 0) check("R1 bit period", cyc - lastRise, 2 * HALF);
        lastRise = cyc;
        lastData = serData;
        if (expQ.size() == 0) check("R4 bit with nothing expected", 1, 0);
        else begin
          got = expQ.pop_front();
          check("R3 R4 data bit", serData, got.d);
          check("R4,R5 channel clock", chanClk, got.c);
        end
      end
      if (!bitClk && prevBit) begin
        check("R1 high time", cyc - lastRise, HALF);
        check("R2 data held through falling edge", serData, lastData);
      end
    end
    prevBit = bitClk;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset bitClk", bitClk, 0);
    check("R8 reset chanClk", chanClk, 1);
    check("R8 reset serData", serData, 0);
    check("R8 reset sampleReady", sampleReady, 0);
    check("R8 reset underrun", underrun, 0);
    rstN = 1'b1;

    runFrame(1, 2'b00, 1, 32'hFFFF_A5C3, 32'h1234_0F0F);
    runFrame(1, 2'b00, 0, 32'h0000_8001, 32'h0000_7FFE);
    runFrame(1, 2'b01, 1, 32'hFFFF_8001, 32'hABCD_C3A5);
    runFrame(1, 2'b10, 0, 32'hDEAD_BEEF, 32'h1357_9BDF);
    runFrame(1, 2'b11, 1, 32'hAB12_3456, 32'h00FE_DCBA);
    runFrame(1, 2'b11, 0, 32'hFF80_0001, 32'h5A7F_FFFE);
    runFrame(0, 2'b01, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runFrame(1, 2'b10, 1, 32'h8000_0001, 32'h7FFF_FFFE);
    runFrame(1, 2'b00, 0, 32'h0000_F00D, 32'h0000_0BAD);
    runFrame(1, 2'b01, 0, 32'h0000_C001, 32'h0000_3FFC);
    runFrame(0, 2'b00, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R6 frame progress: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule